// File: doc/BRIEF.md
# Mirrored memory region address decoder

This block sits between a core's address output and its memory system. It takes a 24-bit physical address with a valid strobe and turns it into one select line per memory region, plus the byte offset inside the selected region. Four regions are decoded: a boot ROM, a main RAM, a small internal RAM and a peripheral I/O space. Three of these regions hold less physical storage than the address window reserved for them. The local offset is therefore folded by the physical size, so the same bytes appear again and again across the window. An address that falls in no region raises an error flag instead of a select.

All outputs are registered and appear one clock after the request. When no request is presented, the outputs fall back to idle: no select, no error and a zero offset. Region bases, window spans, physical sizes and the end of main RAM are parameters. Physical sizes of the folded regions must be powers of two, and main RAM must end at or below the start of the internal RAM window. Breaking either rule stops elaboration with an error.

Top module: `mdec_top`

## Requirements
- R1: An address in 0x000000..0x0FFFFF asserts select bit 0 (ROM). The offset is the address ANDed with (ROM physical size − 1); the default size is 0x40000, giving mask 0x3FFFF.
- R2: An address from 0x100000 up to but excluding the RAM end (default 0x200000) asserts select bit 1 (main RAM). The offset is the address minus 0x100000, with no folding.
- R3: An address in 0xFFE000..0xFFEFFF asserts select bit 2 (internal RAM). The offset is (address − 0xFFE000) AND 0x3FF, so the 1 KB appears four times in the window.
- R4: An address in 0xFFF000..0xFFFFFF asserts select bit 3 (peripheral I/O). The offset is (address − 0xFFF000) AND 0x3FF, so the 1 KB appears four times in the window.
- R5: A valid address in no region, by default 0x200000..0xFFDFFF, sets the error flag, clears all selects and gives offset 0.
- R6: Outputs change only at a clock edge. A request presented before edge N is reflected on the outputs after edge N, and not before it.
- R7: A cycle with valid low gives, after the next edge, all selects low, the error flag low and offset 0.
- R8: At most one select bit is high at any time, and the error flag is never high together with a select.
- R9: While reset is asserted, all selects, the error flag and the offset are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe for the current address |
| req_addr_i | input | ADDR_W (24) | Physical address to decode |
| sel_o | output | 4 | One-hot region select: bit 0 ROM, bit 1 main RAM, bit 2 internal RAM, bit 3 peripheral I/O |
| off_o | output | ADDR_W (24) | Region-local offset, folded by physical size |
| err_o | output | 1 | Unmapped-access flag |

## Verification
Errors in this block show up at the ports one cycle after the address that triggers them. A wrong fold mask shows as offsets that disagree with the modulo value at mirror boundaries such as 0x40000 or 0xFFE400. A wrong window limit shows as a wrong select or a spurious error at the addresses on either side of a boundary. Register state that is not cleared shows on the first idle cycle after a request. For these reasons the sweep covers both small windows densely, probes every boundary ±2, and strides across the whole space with idle cycles mixed in.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  // Number of decoded regions; select bit positions follow region_e.
  localparam int unsigned NUM_REGIONS = 4;

  typedef enum logic [1:0] {
    REG_ROM  = 2'd0,
    REG_RAM  = 2'd1,
    REG_IRAM = 2'd2,
    REG_PIO  = 2'd3
  } region_e;

  // True when v is a non-zero power of two.
  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/mdec_window.sv
// One address window: range match plus optional modulo fold of the offset.
module mdec_window #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned BASE   = 0,
  parameter int unsigned SPAN   = 4096,
  parameter int unsigned PHYS   = 4096
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] off_o
);

  localparam logic [ADDR_W:0]   LO_X   = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0]   HI_X   = (ADDR_W+1)'(BASE + SPAN);
  localparam logic [ADDR_W-1:0] BASE_N = ADDR_W'(BASE);
  localparam bit                FOLD   = (PHYS < SPAN);

  logic [ADDR_W:0]   addr_x;
  logic [ADDR_W-1:0] rel;

  assign addr_x = {1'b0, addr_i};
  assign hit_o  = (addr_x >= LO_X) && (addr_x < HI_X);
  assign rel    = addr_i - BASE_N;

  if (FOLD) begin : g_fold
    localparam logic [ADDR_W-1:0] MASK = ADDR_W'(PHYS - 1);
    assign off_o = rel & MASK;
  end else begin : g_flat
    assign off_o = rel;
  end

endmodule

// File: rtl/mdec_merge.sv
// Gates region hits with the request strobe and merges the offsets.
module mdec_merge #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned N      = 4
) (
  input  logic                      valid_i,
  input  logic [N-1:0]              hit_i,
  input  logic [N-1:0][ADDR_W-1:0]  off_i,
  output logic [N-1:0]              sel_o,
  output logic [ADDR_W-1:0]         off_o,
  output logic                      err_o
);

  always_comb begin
    sel_o = valid_i ? hit_i : '0;
    off_o = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_o[i]) begin
        off_o = off_o | off_i[i];
      end
    end
    err_o = valid_i && (hit_i == '0);
  end

endmodule

// File: rtl/mdec_top.sv
module mdec_top
  import mdec_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned ROM_BASE  = 32'h000000,
  parameter int unsigned ROM_SPAN  = 32'h100000,
  parameter int unsigned ROM_PHYS  = 32'h040000,
  parameter int unsigned RAM_BASE  = 32'h100000,
  parameter int unsigned RAM_END   = 32'h200000,
  parameter int unsigned IRAM_BASE = 32'hFFE000,
  parameter int unsigned IRAM_SPAN = 32'h001000,
  parameter int unsigned IRAM_PHYS = 32'h000400,
  parameter int unsigned PIO_BASE  = 32'hFFF000,
  parameter int unsigned PIO_SPAN  = 32'h001000,
  parameter int unsigned PIO_PHYS  = 32'h000400
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  output logic [NUM_REGIONS-1:0] sel_o,
  output logic [ADDR_W-1:0]      off_o,
  output logic                   err_o
);

  localparam int unsigned RAM_SPAN = RAM_END - RAM_BASE;

  // Per-region tables, indexed by region_e.
  localparam int unsigned WIN_BASE [NUM_REGIONS] = '{ROM_BASE, RAM_BASE, IRAM_BASE, PIO_BASE};
  localparam int unsigned WIN_SPAN [NUM_REGIONS] = '{ROM_SPAN, RAM_SPAN, IRAM_SPAN, PIO_SPAN};
  localparam int unsigned WIN_PHYS [NUM_REGIONS] = '{ROM_PHYS, RAM_SPAN, IRAM_PHYS, PIO_PHYS};

  // ---------------- configuration guards ----------------
  if (RAM_END <= RAM_BASE || RAM_END > IRAM_BASE) begin : g_bad_ram_end
    $error("mdec_top: main RAM end must lie above its base and at or below the internal RAM window");
  end
  if (ROM_BASE + ROM_SPAN > RAM_BASE) begin : g_bad_rom_span
    $error("mdec_top: ROM window overlaps main RAM");
  end
  if (IRAM_BASE + IRAM_SPAN > PIO_BASE) begin : g_bad_iram_span
    $error("mdec_top: internal RAM window overlaps peripheral window");
  end
  if (PIO_BASE + PIO_SPAN > (32'd1 << ADDR_W)) begin : g_bad_pio_span
    $error("mdec_top: peripheral window exceeds the address space");
  end
  if (!is_pow2(ROM_PHYS) || ROM_PHYS > ROM_SPAN) begin : g_bad_rom_phys
    $error("mdec_top: ROM physical size must be a power of two within its window");
  end
  if (!is_pow2(IRAM_PHYS) || IRAM_PHYS > IRAM_SPAN) begin : g_bad_iram_phys
    $error("mdec_top: internal RAM physical size must be a power of two within its window");
  end
  if (!is_pow2(PIO_PHYS) || PIO_PHYS > PIO_SPAN) begin : g_bad_pio_phys
    $error("mdec_top: peripheral physical size must be a power of two within its window");
  end

  // ---------------- region windows ----------------
  logic [NUM_REGIONS-1:0]             hit;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] loc_off;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
    mdec_window #(
      .ADDR_W (ADDR_W),
      .BASE   (WIN_BASE[g]),
      .SPAN   (WIN_SPAN[g]),
      .PHYS   (WIN_PHYS[g])
    ) u_win (
      .addr_i (req_addr_i),
      .hit_o  (hit[g]),
      .off_o  (loc_off[g])
    );
  end

  // ---------------- next state ----------------
  logic [NUM_REGIONS-1:0] sel_d;
  logic [ADDR_W-1:0]      off_d;
  logic                   err_d;

  mdec_merge #(
    .ADDR_W (ADDR_W),
    .N      (NUM_REGIONS)
  ) u_merge (
    .valid_i (req_valid_i),
    .hit_i   (hit),
    .off_i   (loc_off),
    .sel_o   (sel_d),
    .off_o   (off_d),
    .err_o   (err_d)
  );

  // Registers load on a request, or once more to return to idle.
  logic [NUM_REGIONS-1:0] sel_q;
  logic [ADDR_W-1:0]      off_q;
  logic                   err_q;
  logic                   busy_q;
  logic                   cap_en;

  assign busy_q = (|sel_q) | err_q;
  assign cap_en = req_valid_i | busy_q;

  // ---------------- registers ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      off_q <= '0;
      err_q <= 1'b0;
    end else if (cap_en) begin
      sel_q <= sel_d;
      off_q <= off_d;
      err_q <= err_d;
    end
  end

  assign sel_o = sel_q;
  assign off_o = off_q;
  assign err_o = err_q;

endmodule

// File: rtl/mdec_checker.sv
module mdec_checker #(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned NREG      = 4,
  parameter int unsigned ROM_BASE  = 32'h000000,
  parameter int unsigned ROM_SPAN  = 32'h100000,
  parameter int unsigned ROM_PHYS  = 32'h040000,
  parameter int unsigned RAM_END   = 32'h200000,
  parameter int unsigned IRAM_BASE = 32'hFFE000,
  parameter int unsigned PIO_BASE  = 32'hFFF000,
  parameter int unsigned PIO_SPAN  = 32'h001000,
  parameter int unsigned PIO_PHYS  = 32'h000400
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [NREG-1:0]   sel_o,
  input logic [ADDR_W-1:0] off_o,
  input logic              err_o
);

  localparam logic [ADDR_W-1:0] ROM_MASK = ADDR_W'(ROM_PHYS - 1);
  localparam logic [ADDR_W-1:0] ROM_B    = ADDR_W'(ROM_BASE);
  localparam logic [ADDR_W-1:0] PIO_MASK = ADDR_W'(PIO_PHYS - 1);
  localparam logic [ADDR_W-1:0] PIO_B    = ADDR_W'(PIO_BASE);

  logic [31:0] a32;
  assign a32 = 32'(req_addr_i);

  p_sel_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  p_err_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (sel_o == '0));

  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (sel_o == '0 && !err_o && off_o == '0));

  p_answer_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> ((sel_o != '0) || err_o));

  p_rom_fold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && a32 >= ROM_BASE && a32 < ROM_BASE + ROM_SPAN) |=>
      (sel_o[0] && off_o == (($past(req_addr_i) - ROM_B) & ROM_MASK)));

  p_pio_fold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && a32 >= PIO_BASE && a32 < PIO_BASE + PIO_SPAN) |=>
      (sel_o[NREG-1] && off_o == (($past(req_addr_i) - PIO_B) & PIO_MASK)));

  p_unmapped_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && a32 >= RAM_END && a32 < IRAM_BASE) |=>
      (err_o && sel_o == '0 && off_o == '0));

endmodule

bind mdec_top mdec_checker #(
  .ADDR_W    (ADDR_W),
  .NREG      (mdec_pkg::NUM_REGIONS),
  .ROM_BASE  (ROM_BASE),
  .ROM_SPAN  (ROM_SPAN),
  .ROM_PHYS  (ROM_PHYS),
  .RAM_END   (RAM_END),
  .IRAM_BASE (IRAM_BASE),
  .PIO_BASE  (PIO_BASE),
  .PIO_SPAN  (PIO_SPAN),
  .PIO_PHYS  (PIO_PHYS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_addr_i  (req_addr_i),
  .sel_o       (sel_o),
  .off_o       (off_o),
  .err_o       (err_o)
);

// File: tb/tb_mdec_top.sv
`timescale 1ns/1ps
module tb_mdec_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic [3:0]  sel;
  logic [23:0] off;
  logic        err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mdec_top dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_addr_i  (req_addr),
    .sel_o       (sel),
    .off_o       (off),
    .err_o       (err)
  );

  // Previous request, checked one cycle later.
  bit          have_prev = 0;
  logic [23:0] p_addr;
  logic        p_valid;

  task automatic model(input logic [23:0] a, input logic v,
                       output logic [3:0] es, output logic [23:0] eo,
                       output logic ee, output string tag);
    int unsigned x;
    x = a;
    es = 4'b0000; eo = '0; ee = 1'b0;
    if (!v) tag = "R7";
    else if (x < 32'h100000) begin es = 4'b0001; eo = 24'(x % 32'h40000); tag = "R1"; end
    else if (x < 32'h200000) begin es = 4'b0010; eo = 24'(x - 32'h100000); tag = "R2"; end
    else if (x < 32'hFFE000) begin ee = 1'b1; tag = "R5"; end
    else if (x < 32'hFFF000) begin es = 4'b0100; eo = 24'((x - 32'hFFE000) % 32'h400); tag = "R3"; end
    else begin es = 4'b1000; eo = 24'((x - 32'hFFF000) % 32'h400); tag = "R4"; end
  endtask

  task automatic check_prev();
    logic [3:0]  es;
    logic [23:0] eo;
    logic        ee;
    string       tag;
    model(p_addr, p_valid, es, eo, ee, tag);
    checks++;
    if (sel !== es || off !== eo || err !== ee) begin
      errors++;
      $display("FAIL %s addr=%h: sel=%b off=%h err=%b, expected sel=%b off=%h err=%b",
               tag, p_addr, sel, off, err, es, eo, ee);
    end
    checks++;
    if ($countones(sel) > 1 || (err && sel != 4'b0000)) begin
      errors++;
      $display("FAIL R8 addr=%h: sel=%b err=%b, expected at most one select and no select with error",
               p_addr, sel, err);
    end
  endtask

  task automatic step(input logic [23:0] a, input logic v);
    @(negedge clk);
    if (have_prev) check_prev();
    req_addr  = a;
    req_valid = v;
    p_addr    = a;
    p_valid   = v;
    have_prev = 1;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R9: reset state
    checks++;
    if (sel !== 4'b0000 || off !== 24'h0 || err !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: sel=%b off=%h err=%b, expected sel=0000 off=000000 err=0", sel, off, err);
    end
    rst_n = 1'b1;

    // R6: output must not move before the capturing edge
    step(24'hFFF123, 1'b1);
    #1;
    checks++;
    if (sel !== 4'b0000 || err !== 1'b0) begin
      errors++;
      $display("FAIL R6 early change: sel=%b err=%b, expected sel=0000 err=0", sel, err);
    end

    // Dense sweep of the internal RAM and peripheral windows (R3, R4)
    for (int unsigned a = 32'hFFE000; a <= 32'hFFFFFF; a++) begin
      step(24'(a), 1'b1);
    end

    // Boundary neighbourhoods, with an idle cycle after each group (R1, R2, R5, R7)
    begin
      int unsigned edges [12] = '{32'h000000, 32'h03FFFF, 32'h040000, 32'h0FFFFF,
                                  32'h100000, 32'h1FFFFF, 32'h200000, 32'hFFDFFF,
                                  32'hFFE000, 32'hFFE3FF, 32'hFFF000, 32'hFFFFFE};
      for (int e = 0; e < 12; e++) begin
        for (int d = -2; d <= 2; d++) begin
          int signed t;
          t = int'(edges[e]) + d;
          if (t >= 0 && t <= 32'hFFFFFF) step(24'(t), 1'b1);
        end
        step(24'h000123, 1'b0);
      end
    end

    // Strided sweep across the whole space with idle cycles mixed in (R1, R2, R5, R7)
    begin
      int i = 0;
      for (int unsigned a = 0; a < 32'h1000000; a += 32'h1003) begin
        step(24'(a), (i % 7) != 0);
        i++;
      end
    end

    step(24'h0, 1'b0);
    step(24'h0, 1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion within 200000 cycles");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule